// File: doc/BRIEF.md
# Multiplexed Gamepad Scanner

This block polls up to five gamepads that share a single 4-bit, active-low input port. An external 2:1 nibble multiplexer and a pad sequencer sit between the pads and the port. The scanner drives a 2-bit control output. Bit 0 selects the nibble, and bit 1 rewinds the sequencer to pad 0; while bit 1 is low, a rising edge on bit 0 steps the sequencer to the next pad. The scanner waits a settle time after each control change, samples both nibbles of every pad, and stores a merged byte in which 1 means pressed.

For every pad the block keeps the current byte and the byte from the scan before it. It also keeps a mask of the keys that went from released to pressed. When a scan ends it raises a one-cycle done strobe. A reset-request pulse comes with that strobe when a pad that is allowed to request a reset shows the run-plus-select chord completed by a fresh select press. A scan starts on a single-cycle start strobe.

Top module: `pad_scan`

## Requirements
- R1: After reset, ctrl_o is 00, every byte of cur_o, prev_o and edge_o is 0x00, and done_o and reset_req_o are low.
- R2: A scan opens by driving ctrl_o to 01 for SETTLE_CYC cycles, then to 11 for SETTLE_CYC cycles. ctrl_o never takes the value 10.
- R3: After the opening, pads 0 to NUM_PADS-1 are handled in order. For each pad, ctrl_o is 01 for SETTLE_CYC cycles and the port is sampled in the last of them as the upper nibble. ctrl_o is then 00 for SETTLE_CYC cycles and the port is sampled in the last of them as the lower nibble. ctrl_o returns to 00 once the scan is over.
- R4: The stored byte for pad n is the bitwise inverse of {upper nibble, lower nibble} and appears on cur_o[8n+7:8n]. A 1 means pressed, with bit 0 = button I, bit 1 = button II, bit 2 = select, bit 3 = run, bit 5 = right and bit 7 = left.
- R5: When a pad's byte is updated, the value it held before is moved to that pad's slice of prev_o.
- R6: Each pad's slice of edge_o equals (current XOR previous) AND current.
- R7: done_o is high for exactly one cycle. Counting the cycle after the one in which start_i is taken as cycle 1, done_o is high in cycle (2+2*NUM_PADS)*SETTLE_CYC+1, and ctrl_o is 00 in that cycle.
- R8: A start_i pulse while a scan is running has no effect: the control sequence and the done timing are unchanged, and no second scan follows.
- R9: reset_req_o is high together with done_o when, in that scan, some pad n has bit n of RST_EN_MASK set (by default only pad 0), an edge byte of 0x04 and a current byte of 0x0C. Otherwise reset_req_o is low.
- R10: The chord requests no reset when it is held on a pad whose mask bit is clear, or when select and run become pressed in the same scan (edge byte 0x0C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-scan strobe, taken only when idle |
| port_i | input | 4 | Shared active-low nibble port |
| ctrl_o | output | 2 | {rewind, nibble select} to the multiplexer and sequencer |
| cur_o | output | 8*NUM_PADS | Current pressed bytes, pad n at [8n+7:8n] |
| prev_o | output | 8*NUM_PADS | Bytes from the preceding scan |
| edge_o | output | 8*NUM_PADS | Newly pressed keys per pad |
| done_o | output | 1 | One-cycle end-of-scan strobe |
| reset_req_o | output | 1 | Soft-reset chord request, valid with done_o |

## Verification
The bench builds the block with NUM_PADS = 5, SETTLE_CYC = 4 and the default mask of 0x01. The short settle time keeps every scan at 48 cycles, so the whole control trace can be compared on every clock. Five pads leave pads 1 to 4 outside the mask, which exercises both the qualified chord and the masked-off chord. The bench models the multiplexer and sequencer from ctrl_o alone, so a wrong nibble order, a missing inversion or a skipped rewind shows up as the wrong byte on the wrong pad.

// File: rtl/pad_scan_pkg.sv
package pad_scan_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_REWIND,
    ST_HI,
    ST_LO
  } scan_st_e;

  // {rewind, select}
  localparam logic [1:0] CTRL_IDLE   = 2'b00;
  localparam logic [1:0] CTRL_SEL    = 2'b01;
  localparam logic [1:0] CTRL_REWIND = 2'b11;
  localparam logic [1:0] CTRL_LOW    = 2'b00;
endpackage

// File: rtl/pad_scan_seq.sv
module pad_scan_seq
  import pad_scan_pkg::*;
#(
  parameter int NUM_PADS   = 5,
  parameter int SETTLE_CYC = 9,
  parameter int IDX_W      = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [1:0]       ctrl_o,
  output logic             scan_stb_o,
  output logic             hi_stb_o,
  output logic             lo_stb_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  scan_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             tick;

  assign tick       = (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign last_o     = (idx_q == IDX_W'(NUM_PADS - 1));
  assign scan_stb_o = (st_q == ST_IDLE) && start_i;
  assign hi_stb_o   = (st_q == ST_HI) && tick;
  assign lo_stb_o   = (st_q == ST_LO) && tick;
  assign idx_o      = idx_q;
  assign done_o     = done_q;

  always_comb begin
    unique case (st_q)
      ST_OPEN:   ctrl_o = CTRL_SEL;
      ST_REWIND: ctrl_o = CTRL_REWIND;
      ST_HI:     ctrl_o = CTRL_SEL;
      ST_LO:     ctrl_o = CTRL_LOW;
      default:   ctrl_o = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= lo_stb_o && last_o;
      if (st_q == ST_IDLE) begin
        cnt_q <= '0;
        if (start_i) st_q <= ST_OPEN;
      end else if (!tick) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        cnt_q <= '0;
        unique case (st_q)
          ST_OPEN:   st_q <= ST_REWIND;
          ST_REWIND: begin
            st_q  <= ST_HI;
            idx_q <= '0;
          end
          ST_HI:     st_q <= ST_LO;
          ST_LO: begin
            if (last_o) begin
              st_q  <= ST_IDLE;
              idx_q <= '0;
            end else begin
              st_q  <= ST_HI;
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          default:   st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pad_scan_regs.sv
module pad_scan_regs
  import pad_scan_pkg::*;
#(
  parameter int NUM_PADS = 5,
  parameter int IDX_W    = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NIB_W-1:0]           port_i,
  input  logic                       hi_stb_i,
  input  logic                       lo_stb_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [BYTE_W-1:0]          new_byte_o,
  output logic [BYTE_W-1:0]          new_edge_o,
  output logic [NUM_PADS*BYTE_W-1:0] cur_o,
  output logic [NUM_PADS*BYTE_W-1:0] prev_o,
  output logic [NUM_PADS*BYTE_W-1:0] edge_o
);
  logic [NIB_W-1:0]  hi_q;
  logic [BYTE_W-1:0] cur_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_q <= '0;
    else if (hi_stb_i) hi_q <= port_i;
  end

  // keys pull low when pressed
  assign new_byte_o = ~{hi_q, port_i};

  always_comb begin
    cur_sel = '0;
    for (int k = 0; k < NUM_PADS; k++)
      if (idx_i == IDX_W'(k)) cur_sel = cur_o[k*BYTE_W +: BYTE_W];
  end

  assign new_edge_o = (new_byte_o ^ cur_sel) & new_byte_o;

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    logic [BYTE_W-1:0] cur_q, prev_q, edge_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q  <= '0;
        prev_q <= '0;
        edge_q <= '0;
      end else if (lo_stb_i && idx_i == IDX_W'(g)) begin
        prev_q <= cur_q;
        cur_q  <= new_byte_o;
        edge_q <= new_edge_o;
      end
    end
    assign cur_o[g*BYTE_W +: BYTE_W]  = cur_q;
    assign prev_o[g*BYTE_W +: BYTE_W] = prev_q;
    assign edge_o[g*BYTE_W +: BYTE_W] = edge_q;
  end
endmodule

// File: rtl/pad_scan_chord.sv
module pad_scan_chord
  import pad_scan_pkg::*;
#(
  parameter int          NUM_PADS    = 5,
  parameter int          IDX_W       = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1,
  parameter logic [7:0]  RST_EN_MASK = 8'h01,
  parameter logic [7:0]  CHORD_NEW   = 8'h04,
  parameter logic [7:0]  CHORD_HELD  = 8'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_stb_i,
  input  logic              lo_stb_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] new_byte_i,
  input  logic [BYTE_W-1:0] new_edge_i,
  output logic              req_o
);
  logic pad_en, hit, seen_q, req_q;

  always_comb begin
    pad_en = 1'b0;
    for (int k = 0; k < 8; k++)
      if (k < NUM_PADS && idx_i == IDX_W'(k)) pad_en = RST_EN_MASK[k];
  end

  assign hit = lo_stb_i && pad_en && (new_edge_i == CHORD_NEW) && (new_byte_i == CHORD_HELD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (scan_stb_i) seen_q <= 1'b0;
      else if (hit)   seen_q <= 1'b1;
      req_q <= lo_stb_i && last_i && (seen_q || hit);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/pad_scan.sv
module pad_scan
  import pad_scan_pkg::*;
#(
  parameter int         NUM_PADS    = 5,
  parameter int         SETTLE_CYC  = 9,
  parameter logic [7:0] RST_EN_MASK = 8'h01,
  parameter logic [7:0] CHORD_NEW   = 8'h04,
  parameter logic [7:0] CHORD_HELD  = 8'h0C
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [3:0]                 port_i,
  output logic [1:0]                 ctrl_o,
  output logic [NUM_PADS*8-1:0]      cur_o,
  output logic [NUM_PADS*8-1:0]      prev_o,
  output logic [NUM_PADS*8-1:0]      edge_o,
  output logic                       done_o,
  output logic                       reset_req_o
);
  localparam int IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic              scan_stb, hi_stb, lo_stb, last;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] new_byte, new_edge;

  pad_scan_seq #(
    .NUM_PADS(NUM_PADS), .SETTLE_CYC(SETTLE_CYC), .IDX_W(IDX_W)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ctrl_o(ctrl_o),
    .scan_stb_o(scan_stb), .hi_stb_o(hi_stb), .lo_stb_o(lo_stb),
    .last_o(last), .idx_o(idx), .done_o(done_o)
  );

  pad_scan_regs #(
    .NUM_PADS(NUM_PADS), .IDX_W(IDX_W)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .port_i(port_i), .hi_stb_i(hi_stb),
    .lo_stb_i(lo_stb), .idx_i(idx), .new_byte_o(new_byte), .new_edge_o(new_edge),
    .cur_o(cur_o), .prev_o(prev_o), .edge_o(edge_o)
  );

  pad_scan_chord #(
    .NUM_PADS(NUM_PADS), .IDX_W(IDX_W), .RST_EN_MASK(RST_EN_MASK),
    .CHORD_NEW(CHORD_NEW), .CHORD_HELD(CHORD_HELD)
  ) i_chord (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_stb_i(scan_stb), .lo_stb_i(lo_stb),
    .last_i(last), .idx_i(idx), .new_byte_i(new_byte), .new_edge_i(new_edge),
    .req_o(reset_req_o)
  );
endmodule

// File: rtl/pad_scan_chk.sv
module pad_scan_chk #(
  parameter int NUM_PADS = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            ctrl_o,
  input logic [NUM_PADS*8-1:0] cur_o,
  input logic [NUM_PADS*8-1:0] edge_o,
  input logic                  done_o,
  input logic                  reset_req_o
);
  a_r2_no_ctrl_10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o != 2'b10);

  a_r2_rewind_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[1]) |-> ctrl_o == 2'b01);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ctrl_o == 2'b00);

  a_r9_req_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> done_o);

  a_r6_edge_in_cur: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o & ~cur_o) == '0);
endmodule

bind pad_scan pad_scan_chk #(.NUM_PADS(NUM_PADS)) i_pad_scan_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_o(ctrl_o), .cur_o(cur_o),
  .edge_o(edge_o), .done_o(done_o), .reset_req_o(reset_req_o)
);

// File: tb/test_pad_scan.sv
module test_pad_scan;
  localparam int         NP    = 5;
  localparam int         ST    = 4;
  localparam int         TOTAL = ST * (2 + 2 * NP);
  localparam logic [7:0] EN    = 8'h01;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [3:0]      port_i;
  logic [1:0]      ctrl_o;
  logic [NP*8-1:0] cur_o, prev_o, edge_o;
  logic            done_o, reset_req_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] pads [NP];
  logic [7:0] e_cur [NP];
  logic [7:0] e_prev [NP];
  int         midx = 0;
  logic       last_sel = 1'b0;

  always #4 clk = ~clk;

  pad_scan #(.NUM_PADS(NP), .SETTLE_CYC(ST)) i_pad_scan (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .port_i(port_i),
    .ctrl_o(ctrl_o), .cur_o(cur_o), .prev_o(prev_o), .edge_o(edge_o),
    .done_o(done_o), .reset_req_o(reset_req_o)
  );

  // external sequencer and nibble multiplexer
  always @(ctrl_o) begin
    if (ctrl_o[1]) midx = 0;
    else if (ctrl_o[0] && !last_sel) midx = midx + 1;
    last_sel = ctrl_o[0];
  end

  always_comb begin
    if (midx >= 0 && midx < NP)
      port_i = ~(ctrl_o[0] ? pads[midx][7:4] : pads[midx][3:0]);
    else
      port_i = 4'hF;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic scan(input bit poke);
    logic [1:0] q[$];
    logic       e_req = 1'b0;
    logic [7:0] e_edge [NP];
    for (int i = 0; i < ST; i++) q.push_back(2'b01);
    for (int i = 0; i < ST; i++) q.push_back(2'b11);
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < ST; i++) q.push_back(2'b01);
      for (int i = 0; i < ST; i++) q.push_back(2'b00);
    end
    for (int p = 0; p < NP; p++) begin
      e_prev[p] = e_cur[p];
      e_cur[p]  = pads[p];
      e_edge[p] = (e_cur[p] ^ e_prev[p]) & e_cur[p];
      if (p < 8 && EN[p] && e_edge[p] == 8'h04 && e_cur[p] == 8'h0C) e_req = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b1;
    for (int n = 1; n <= TOTAL; n++) begin
      @(negedge clk);
      start_i = poke && (n == 5);
      chk(ctrl_o == q[n-1], (n <= 2 * ST) ? "R2 open" : (poke ? "R8 ctrl" : "R3 ctrl"),
          64'(ctrl_o), 64'(q[n-1]));
      chk(!done_o, "R7 early done", 64'(done_o), 64'h0);
    end
    @(negedge clk);
    chk(done_o, "R7 done", 64'(done_o), 64'h1);
    chk(ctrl_o == 2'b00, "R3 idle after scan", 64'(ctrl_o), 64'h0);
    chk(reset_req_o == e_req, e_req ? "R9 req" : "R10 no req", 64'(reset_req_o), 64'(e_req));
    for (int p = 0; p < NP; p++) begin
      chk(cur_o[p*8 +: 8] == e_cur[p], "R4 cur", 64'(cur_o[p*8 +: 8]), 64'(e_cur[p]));
      chk(prev_o[p*8 +: 8] == e_prev[p], "R5 prev", 64'(prev_o[p*8 +: 8]), 64'(e_prev[p]));
      chk(edge_o[p*8 +: 8] == e_edge[p], "R6 edge", 64'(edge_o[p*8 +: 8]), 64'(e_edge[p]));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!done_o, "R7 single done", 64'(done_o), 64'h0);
      chk(ctrl_o == 2'b00, poke ? "R8 no rescan" : "R3 stays idle", 64'(ctrl_o), 64'h0);
    end
  endtask

  task automatic set_pads(input logic [7:0] a, b, c, d, e);
    pads[0] = a; pads[1] = b; pads[2] = c; pads[3] = d; pads[4] = e;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      pads[p] = 8'h00;
      e_cur[p] = 8'h00;
      e_prev[p] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_o == 2'b00, "R1 ctrl", 64'(ctrl_o), 64'h0);
    chk(cur_o == '0, "R1 cur", 64'(cur_o), 64'h0);
    chk(prev_o == '0, "R1 prev", 64'(prev_o), 64'h0);
    chk(edge_o == '0, "R1 edge", 64'(edge_o), 64'h0);
    chk(!done_o && !reset_req_o, "R1 strobes", 64'({done_o, reset_req_o}), 64'h0);

    set_pads(8'h00, 8'h00, 8'h00, 8'h00, 8'h00); scan(1'b0);
    set_pads(8'h21, 8'h82, 8'hFF, 8'h5A, 8'h00); scan(1'b0);  // R4 distinct bytes
    set_pads(8'h01, 8'h82, 8'h0F, 8'hA5, 8'h80); scan(1'b0);  // R5 R6 changes
    set_pads(8'h08, 8'h08, 8'h00, 8'h00, 8'h00); scan(1'b0);
    set_pads(8'h08, 8'h0C, 8'h00, 8'h00, 8'h00); scan(1'b0);  // R10 masked pad
    set_pads(8'h0C, 8'h0C, 8'h00, 8'h00, 8'h00); scan(1'b0);  // R9 chord on pad 0
    set_pads(8'h00, 8'h00, 8'h00, 8'h00, 8'h00); scan(1'b0);
    set_pads(8'h0C, 8'h00, 8'h00, 8'h00, 8'h00); scan(1'b0);  // R10 both at once
    set_pads(8'h33, 8'hCC, 8'h11, 8'h22, 8'h44); scan(1'b1);  // R8 start while busy

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule